// File: doc/BRIEF.md
# Multidrop Test-Bus Board Selector

This block sits behind the backplane IEEE 1149.1 TAP of one board on a shared multidrop test bus. Every board on the bus sees the same TCK, TMS and TDI. A test master selects one board, or several, by shifting an address into the instruction register. Each board compares that address against its own 7-bit slot identifier, which is strapped on static input pins. Only the selected boards go on to act on later scans.

An address is one of six kinds. It can be a unique slot match, a broadcast that selects every board, an interrogation address that also reaches every board, one of four multicast group addresses, the reserved all-zero value, or a value that matches nothing. Multicast membership comes from per-board group pins. When several boards may be selected at once, the backplane TDO driver stays disabled so that no two boards ever drive it together. Only a board picked by its unique slot address drives TDO, and it does so only while shifting. A selected board keeps its selection until it scans the all-zero instruction, until the TAP passes through Test-Logic-Reset, or until the TRST input is asserted. Routing to the local scan ports is not part of this block.

Top module: `mds_addr_selector`

## Requirements
- R1: A rising TCK edge with `trst` high puts the TAP in Test-Logic-Reset and clears the selection: `selected`=0, `sel_kind`=0, `sel_group`=0, `tdo_oe`=0.
- R2: An unselected board whose instruction register holds its own `slot_id` at the edge taken in Update-IR becomes selected with `sel_kind`=1 (unique). The register is shifted least significant bit first, 7 bits, and the outputs change at that edge.
- R3: Address 7'h3B (broadcast) selects every unselected board with `sel_kind`=2, whatever its slot.
- R4: Address 7'h3A (interrogation) selects every unselected board with `sel_kind`=3, whatever its slot.
- R5: Addresses 7'h3C+g, for g in 0..3, select a board with `sel_kind`=4 and `sel_group`=g only if `grp_member[g]` is 1. Otherwise the board stays unselected. `sel_group` is 0 for every other kind.
- R6: The all-zero address never selects a board. Any other address that matches no rule above also leaves an unselected board unselected.
- R7: `tdo_oe` is 1 only for a unique selection while the TAP is in Shift-IR or Shift-DR. `tdo` then carries the scan bit: the IR captures 7'b0000001 and the one-bit bypass captures 0.
- R8: `selected`, `sel_kind` and `sel_group` change only at an edge taken in Update-IR or Test-Logic-Reset, or at a TRST edge. Data-register scans never change them.
- R9: Five TCK edges with TMS high reach Test-Logic-Reset from any state, and the board leaves that state unselected.
- R10: On a selected board, an Update-IR with the all-zero instruction releases the selection. Any other instruction keeps the selection and its kind.
- R11: An unselected board keeps tracking the TAP state from TMS through scans it does not respond to, so a later address scan still selects it correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| trst | input | 1 | Synchronous active-high test reset |
| tms | input | 1 | Test mode select from the backplane |
| tdi | input | 1 | Serial test data in from the backplane |
| slot_id | input | 7 | Strapped slot address of this board |
| grp_member | input | 4 | Bit g set: board belongs to multicast group g |
| tdo | output | 1 | Serial test data out (0 while not enabled) |
| tdo_oe | output | 1 | Enable for the backplane TDO driver |
| selected | output | 1 | Board is currently selected |
| sel_kind | output | 3 | 0 none, 1 unique, 2 broadcast, 3 interrogation, 4 multicast |
| sel_group | output | 2 | Multicast group index when `sel_kind`=4 |

## Verification
The bench targets the all-zero address in both roles: as an address it must not select a board, and as an instruction it must release a board that is selected. A decoder that folds these two roles together either selects slot-less boards or leaves boards stuck on the bus. It scans a group address for a board that is not a member, which a design that ignores the membership pins would wrongly accept. It checks `tdo_oe` during broadcast and interrogation shifts, where a wrong enable would put several drivers on one wire. It also puts non-matching scans, DR scans and TMS-only resets between addressings, so that a board which stops following TMS while unselected loses step and misses its next address.

// File: rtl/mds_pkg.sv
package mds_pkg;

    typedef enum logic [3:0] {
        TAP_RESET,
        TAP_IDLE,
        TAP_SEL_DR,
        TAP_CAP_DR,
        TAP_SHIFT_DR,
        TAP_EXIT1_DR,
        TAP_PAUSE_DR,
        TAP_EXIT2_DR,
        TAP_UPD_DR,
        TAP_SEL_IR,
        TAP_CAP_IR,
        TAP_SHIFT_IR,
        TAP_EXIT1_IR,
        TAP_PAUSE_IR,
        TAP_EXIT2_IR,
        TAP_UPD_IR
    } tap_state_e;

    typedef enum logic [2:0] {
        KIND_NONE   = 3'd0,
        KIND_UNIQUE = 3'd1,
        KIND_BCAST  = 3'd2,
        KIND_INTG   = 3'd3,
        KIND_MCAST  = 3'd4
    } sel_kind_e;

    typedef struct packed {
        logic      active;
        sel_kind_e kind;
    } sel_state_t;

    localparam sel_state_t SEL_IDLE = '{active: 1'b0, kind: KIND_NONE};

    function automatic tap_state_e tap_next(tap_state_e s, logic tms);
        tap_state_e n;
        case (s)
            TAP_RESET:    n = tms ? TAP_RESET    : TAP_IDLE;
            TAP_IDLE:     n = tms ? TAP_SEL_DR   : TAP_IDLE;
            TAP_SEL_DR:   n = tms ? TAP_SEL_IR   : TAP_CAP_DR;
            TAP_CAP_DR:   n = tms ? TAP_EXIT1_DR : TAP_SHIFT_DR;
            TAP_SHIFT_DR: n = tms ? TAP_EXIT1_DR : TAP_SHIFT_DR;
            TAP_EXIT1_DR: n = tms ? TAP_UPD_DR   : TAP_PAUSE_DR;
            TAP_PAUSE_DR: n = tms ? TAP_EXIT2_DR : TAP_PAUSE_DR;
            TAP_EXIT2_DR: n = tms ? TAP_UPD_DR   : TAP_SHIFT_DR;
            TAP_UPD_DR:   n = tms ? TAP_SEL_DR   : TAP_IDLE;
            TAP_SEL_IR:   n = tms ? TAP_RESET    : TAP_CAP_IR;
            TAP_CAP_IR:   n = tms ? TAP_EXIT1_IR : TAP_SHIFT_IR;
            TAP_SHIFT_IR: n = tms ? TAP_EXIT1_IR : TAP_SHIFT_IR;
            TAP_EXIT1_IR: n = tms ? TAP_UPD_IR   : TAP_PAUSE_IR;
            TAP_PAUSE_IR: n = tms ? TAP_EXIT2_IR : TAP_PAUSE_IR;
            TAP_EXIT2_IR: n = tms ? TAP_UPD_IR   : TAP_SHIFT_IR;
            TAP_UPD_IR:   n = tms ? TAP_SEL_DR   : TAP_IDLE;
            default:      n = TAP_RESET;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/mds_tap_ctrl.sv
module mds_tap_ctrl
    import mds_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state
);

    always_ff @(posedge tck) begin
        if (rst) begin
            state <= TAP_RESET;
        end else begin
            state <= tap_next(state, tms);
        end
    end

endmodule

// File: rtl/mds_scan_path.sv
module mds_scan_path
    import mds_pkg::*;
#(
    parameter int IR_W = 7
) (
    input  logic            tck,
    input  logic            rst,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic [IR_W-1:0] ir_q,
    output logic            scan_bit
);

    localparam logic [IR_W-1:0] IR_CAPTURE = IR_W'(1);

    logic bypass_q;

    always_ff @(posedge tck) begin
        if (rst) begin
            ir_q     <= '0;
            bypass_q <= 1'b0;
        end else begin
            case (state)
                TAP_CAP_IR:   ir_q     <= IR_CAPTURE;
                TAP_SHIFT_IR: ir_q     <= {tdi, ir_q[IR_W-1:1]};
                TAP_CAP_DR:   bypass_q <= 1'b0;
                TAP_SHIFT_DR: bypass_q <= tdi;
                default: ;
            endcase
        end
    end

    always_comb begin
        scan_bit = (state == TAP_SHIFT_IR) ? ir_q[0] : bypass_q;
    end

endmodule

// File: rtl/mds_addr_classify.sv
module mds_addr_classify
    import mds_pkg::*;
#(
    parameter int                ADDR_W     = 7,
    parameter int                N_GROUPS   = 4,
    parameter logic [ADDR_W-1:0] BCAST_CODE = 7'h3B,
    parameter logic [ADDR_W-1:0] INTG_CODE  = 7'h3A,
    parameter logic [ADDR_W-1:0] MCAST_BASE = 7'h3C,
    localparam int               GRP_W      = (N_GROUPS > 1) ? $clog2(N_GROUPS) : 1
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [ADDR_W-1:0]   slot_id,
    input  logic [N_GROUPS-1:0] grp_member,
    output sel_kind_e           kind,
    output logic [GRP_W-1:0]    grp
);

    logic [N_GROUPS-1:0] code_hit;
    logic [N_GROUPS-1:0] grp_hit;

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_group
        assign code_hit[g] = (addr == MCAST_BASE + ADDR_W'(g));
        assign grp_hit[g]  = code_hit[g] & grp_member[g];
    end

    always_comb begin
        kind = KIND_NONE;
        grp  = '0;
        if (addr == '0) begin
            kind = KIND_NONE;
        end else if (addr == BCAST_CODE) begin
            kind = KIND_BCAST;
        end else if (addr == INTG_CODE) begin
            kind = KIND_INTG;
        end else if (|code_hit) begin
            if (|grp_hit) begin
                kind = KIND_MCAST;
                for (int i = 0; i < N_GROUPS; i++) begin
                    if (grp_hit[i]) begin
                        grp = GRP_W'(i);
                    end
                end
            end
        end else if (addr == slot_id) begin
            kind = KIND_UNIQUE;
        end
    end

endmodule

// File: rtl/mds_addr_selector.sv
module mds_addr_selector
    import mds_pkg::*;
#(
    parameter int                ADDR_W       = 7,
    parameter int                N_GROUPS     = 4,
    parameter logic [ADDR_W-1:0] BCAST_CODE   = 7'h3B,
    parameter logic [ADDR_W-1:0] INTG_CODE    = 7'h3A,
    parameter logic [ADDR_W-1:0] MCAST_BASE   = 7'h3C,
    parameter logic [ADDR_W-1:0] RELEASE_CODE = '0,
    localparam int               GRP_W        = (N_GROUPS > 1) ? $clog2(N_GROUPS) : 1
) (
    input  logic                tck,
    input  logic                trst,
    input  logic                tms,
    input  logic                tdi,
    input  logic [ADDR_W-1:0]   slot_id,
    input  logic [N_GROUPS-1:0] grp_member,
    output logic                tdo,
    output logic                tdo_oe,
    output logic                selected,
    output logic [2:0]          sel_kind,
    output logic [GRP_W-1:0]    sel_group
);

    tap_state_e        tap_st;
    logic [ADDR_W-1:0] ir_q;
    logic              scan_bit;
    sel_kind_e         cls_kind;
    logic [GRP_W-1:0]  cls_grp;
    sel_state_t        sel_q;
    logic [GRP_W-1:0]  grp_q;

    mds_tap_ctrl u_tap (
        .tck   (tck),
        .rst   (trst),
        .tms   (tms),
        .state (tap_st)
    );

    mds_scan_path #(.IR_W(ADDR_W)) u_scan (
        .tck      (tck),
        .rst      (trst),
        .state    (tap_st),
        .tdi      (tdi),
        .ir_q     (ir_q),
        .scan_bit (scan_bit)
    );

    mds_addr_classify #(
        .ADDR_W     (ADDR_W),
        .N_GROUPS   (N_GROUPS),
        .BCAST_CODE (BCAST_CODE),
        .INTG_CODE  (INTG_CODE),
        .MCAST_BASE (MCAST_BASE)
    ) u_cls (
        .addr       (ir_q),
        .slot_id    (slot_id),
        .grp_member (grp_member),
        .kind       (cls_kind),
        .grp        (cls_grp)
    );

    // Selection changes only at an edge taken in Update-IR, or on reset.
    always_ff @(posedge tck) begin
        if (trst || tap_st == TAP_RESET) begin
            sel_q <= SEL_IDLE;
            grp_q <= '0;
        end else if (tap_st == TAP_UPD_IR) begin
            if (!sel_q.active) begin
                if (cls_kind != KIND_NONE) begin
                    sel_q <= '{active: 1'b1, kind: cls_kind};
                    grp_q <= cls_grp;
                end
            end else if (ir_q == RELEASE_CODE) begin
                sel_q <= SEL_IDLE;
                grp_q <= '0;
            end
        end
    end

    logic in_shift;
    assign in_shift  = (tap_st == TAP_SHIFT_IR) || (tap_st == TAP_SHIFT_DR);
    assign tdo_oe    = sel_q.active && (sel_q.kind == KIND_UNIQUE) && in_shift;
    assign tdo       = tdo_oe & scan_bit;
    assign selected  = sel_q.active;
    assign sel_kind  = sel_q.kind;
    assign sel_group = grp_q;

endmodule

// File: rtl/mds_sel_checker.sv
module mds_sel_checker #(
    parameter int                ADDR_W     = 7,
    parameter int                N_GROUPS   = 4,
    parameter logic [ADDR_W-1:0] BCAST_CODE = 7'h3B,
    parameter logic [ADDR_W-1:0] INTG_CODE  = 7'h3A,
    parameter logic [ADDR_W-1:0] MCAST_BASE = 7'h3C
) (
    input logic              tck,
    input logic              trst,
    input logic [3:0]        st,
    input logic [ADDR_W-1:0] ir,
    input logic [ADDR_W-1:0] slot_id,
    input logic              selected,
    input logic [2:0]        kind
);
    import mds_pkg::*;

    logic              upd;
    logic [ADDR_W-1:0] slot_off;
    logic              slot_ok;

    assign upd      = (st == TAP_UPD_IR);
    assign slot_off = slot_id - MCAST_BASE;
    assign slot_ok  = (slot_id != '0) && (slot_id != BCAST_CODE) &&
                      (slot_id != INTG_CODE) && (int'(slot_off) >= N_GROUPS);

    assert_tlr_unselects_R9: assert property (@(posedge tck) disable iff (trst)
        (st == TAP_RESET) |=> !selected);

    assert_unique_hit_R2: assert property (@(posedge tck) disable iff (trst)
        (upd && !selected && slot_ok && ir == slot_id) |=> (selected && kind == 3'd1));

    assert_bcast_hit_R3: assert property (@(posedge tck) disable iff (trst)
        (upd && !selected && ir == BCAST_CODE) |=> (selected && kind == 3'd2));

    assert_intg_hit_R4: assert property (@(posedge tck) disable iff (trst)
        (upd && !selected && ir == INTG_CODE) |=> (selected && kind == 3'd3));

    assert_zero_never_R6: assert property (@(posedge tck) disable iff (trst)
        (upd && !selected && ir == '0) |=> !selected);

    assert_release_R10: assert property (@(posedge tck) disable iff (trst)
        (upd && selected && ir == '0) |=> !selected);

    assert_keep_R10: assert property (@(posedge tck) disable iff (trst)
        (upd && selected && ir != '0) |=> (selected && $stable(kind)));

    assert_hold_R8: assert property (@(posedge tck) disable iff (trst)
        (!upd && st != TAP_RESET) |=> ($stable(selected) && $stable(kind)));

endmodule

bind mds_addr_selector mds_sel_checker #(
    .ADDR_W     (ADDR_W),
    .N_GROUPS   (N_GROUPS),
    .BCAST_CODE (BCAST_CODE),
    .INTG_CODE  (INTG_CODE),
    .MCAST_BASE (MCAST_BASE)
) u_sel_chk (
    .tck      (tck),
    .trst     (trst),
    .st       (tap_st),
    .ir       (ir_q),
    .slot_id  (slot_id),
    .selected (selected),
    .kind     (sel_kind)
);

// File: tb/mds_addr_selector_tb_top.sv
`timescale 1ns/1ps
module mds_addr_selector_tb_top;

    localparam int WATCHDOG = 150000;

    logic       tck = 1'b0;
    logic       trst = 1'b1;
    logic       tms = 1'b1;
    logic       tdi = 1'b0;
    logic [6:0] slot_id = 7'h15;
    logic [3:0] grp_member = 4'b0101;
    logic       tdo, tdo_oe, selected;
    logic [2:0] sel_kind;
    logic [1:0] sel_group;

    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;
    logic [5:0] exp_st = '0;   // {selected, kind, group}

    always #4 tck = ~tck;      // 125 MHz

    mds_addr_selector dut_i (
        .tck(tck), .trst(trst), .tms(tms), .tdi(tdi),
        .slot_id(slot_id), .grp_member(grp_member),
        .tdo(tdo), .tdo_oe(tdo_oe), .selected(selected),
        .sel_kind(sel_kind), .sel_group(sel_group)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [5:0] model_update(logic [5:0] cur, logic [6:0] a,
                                                logic [6:0] slot, logic [3:0] grp);
        if (cur[5]) return (a == 7'h00) ? 6'd0 : cur;
        if (a == 7'h00) return 6'd0;
        if (a == 7'h3B) return {1'b1, 3'd2, 2'd0};
        if (a == 7'h3A) return {1'b1, 3'd3, 2'd0};
        if (a >= 7'h3C && a <= 7'h3F) begin
            logic [1:0] g = 2'(a - 7'h3C);
            return grp[g] ? {1'b1, 3'd4, g} : 6'd0;
        end
        if (a == slot) return {1'b1, 3'd1, 2'd0};
        return 6'd0;
    endfunction

    function automatic string req_of(logic [5:0] cur, logic [6:0] a);
        if (cur[5]) return "R10";
        if (a == 7'h00) return "R6";
        if (a == 7'h3B) return "R3";
        if (a == 7'h3A) return "R4";
        if (a >= 7'h3C && a <= 7'h3F) return "R5";
        return "R2/R6/R11";
    endfunction

    function automatic logic exp_oe();
        return exp_st[5] && exp_st[4:2] == 3'd1;
    endfunction

    // Inputs change at a falling edge; the task returns at the next falling edge.
    task automatic step(logic m, logic d);
        tms = m;
        tdi = d;
        @(negedge tck);
    endtask

    task automatic chk_state(string req);
        chk(req, {selected, sel_kind, sel_group}, exp_st);
    endtask

    task automatic scan_ir(logic [6:0] a);
        string rq;
        rq = req_of(exp_st, a);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);   // now in Shift-IR
        for (int i = 0; i < 7; i++) begin
            chk("R7 oe in Shift-IR", tdo_oe, exp_oe());
            if (exp_oe()) chk("R7 tdo in Shift-IR", tdo, (i == 0));
            step(i == 6, a[i]);
        end
        step(1, 0);                                        // Update-IR
        chk_state("R8 before update");
        step(0, 0);                                        // Run-Test/Idle
        exp_st = model_update(exp_st, a, slot_id, grp_member);
        chk_state(rq);
        chk("R7 oe idle", tdo_oe, 0);
    endtask

    task automatic scan_dr();
        step(1, 0); step(0, 0); step(0, 0);                // now in Shift-DR
        chk("R7 oe in Shift-DR", tdo_oe, exp_oe());
        if (exp_oe()) chk("R7 bypass capture", tdo, 0);
        step(0, 1);
        if (exp_oe()) chk("R7 bypass shift", tdo, 1);
        step(1, 0); step(1, 0); step(0, 0);
        chk_state("R8 DR scan");
    endtask

    task automatic tms_reset();
        for (int i = 0; i < 5; i++) step(1, 0);
        exp_st = '0;
        chk_state("R9 five TMS ones");
        step(0, 0);
    endtask

    task automatic pulse_trst();
        trst = 1'b1;
        step(0, 0);
        exp_st = '0;
        chk_state("R1 trst");
        chk("R1 oe", tdo_oe, 0);
        trst = 1'b0;
        step(0, 0);
    endtask

    task automatic new_pins();
        logic [6:0] s;
        do s = 7'($urandom % 128);
        while (s == 7'h00 || s == 7'h3A || s == 7'h3B || (s >= 7'h3C && s <= 7'h3F));
        slot_id = s;
        grp_member = 4'($urandom);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        void'($urandom(32'd7321));
        // R1: reset state
        step(1, 0); step(1, 0);
        chk_state("R1 reset");
        chk("R1 oe", tdo_oe, 0);
        trst = 1'b0;
        step(0, 0);
        // Directed corner cases
        scan_ir(slot_id);          // R2 unique
        scan_dr();                 // R7 tdo drive
        scan_ir(7'h55);            // R10 keep
        scan_ir(7'h00);            // R10 release
        scan_ir(7'h00);            // R6 zero never selects
        scan_ir(7'h3B);            // R3 broadcast, oe stays off
        scan_dr();
        tms_reset();               // R9
        scan_ir(7'h3A);            // R4 interrogation
        pulse_trst();              // R1
        scan_ir(7'h3C);            // R5 member of group 0
        tms_reset();
        scan_ir(7'h3D);            // R5 not a member of group 1
        scan_ir(slot_id + 7'd1);   // R6 mismatch
        scan_dr();
        scan_ir(7'h3F);            // R5 not a member of group 3
        scan_ir(slot_id);          // R11 still in step, selects
        chk("R11 tracked", selected, 1);
        // Constrained random phase
        for (int n = 0; n < 300; n++) begin
            int op = $urandom % 9;
            if (op <= 4) begin
                logic [6:0] a;
                case ($urandom % 6)
                    0: a = slot_id;
                    1: a = 7'h3B;
                    2: a = 7'h3A;
                    3: a = 7'h3C + 7'($urandom % 4);
                    4: a = 7'h00;
                    default: a = 7'($urandom % 128);
                endcase
                scan_ir(a);
            end else if (op <= 6) begin
                scan_dr();
            end else if (op == 7) begin
                tms_reset();
                new_pins();
            end else begin
                pulse_trst();
                new_pins();
            end
        end
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge tck);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

endmodule